// File: doc/BRIEF.md
# Colour Clock Phase Strobe Generator

This block splits each colour clock period into four quarter phases and marks each phase with a one-cycle enable strobe. It has one clock domain, `clk`. The 7 MHz reference level (`ref_i`) and the colour clock level (`cck_i`), which runs at half the reference rate, arrive as plain data inputs. The block samples them through a synchronizer. It never uses either one as a flip-flop clock edge. The quadrature colour clock is rebuilt as the XOR of the two sampled levels, and the pair (colour clock, quadrature) gives a two-bit phase index.

A mouse line bundle is time-multiplexed on the colour clock level. The block samples it at the middle of each colour clock half, where the quadrature level toggles and the line is settled. Samples taken while the colour clock is high go to channel A. Samples taken while it is low go to channel B. Each channel holds its value until the next capture. The strobes, the rebuilt quadrature level and the two channels are the outputs. Other logic uses them as clock enables.

Top module: `ccs_strobe_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `ph_stb_o`, `phase_valid_o`, `cckq_o`, `phase_o`, `mouse_a_o` and `mouse_b_o` to zero after that edge.
- R2: `cckq_o` equals `ref_i` XOR `cck_i`. It appears SYNC_STAGES+1 clock edges after the inputs change.
- R3: `phase_o` encodes the sampled pair (cck, cckq) with the same latency as R2: (1,0) gives 0, (1,1) gives 1, (0,1) gives 2 and (0,0) gives 3.
- R4: `ph_stb_o[k]` is high for exactly one cycle when `phase_o` changes to k. With a well-formed colour clock, each of the four bits fires exactly once per period, and at most one bit is high in any cycle.
- R5: After reset, `phase_valid_o` rises on the second clock edge. No strobe fires before that, even if the phase index changes.
- R6: On a strobe of phase 1, `mouse_a_o` loads the mouse value sampled in step with that phase, one cycle after the strobe. At all other times it holds.
- R7: On a strobe of phase 3, `mouse_b_o` loads the mouse value sampled in step with that phase, one cycle after the strobe. At all other times it holds.
- R8: When the colour clock and reference stop, no strobe fires. Mouse input changes then have no effect on either channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every flip-flop uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | 7 MHz reference level, sampled as data |
| cck_i | input | 1 | Colour clock level, sampled as data |
| mouse_i | input | MOUSE_W | Multiplexed mouse lines |
| cckq_o | output | 1 | Rebuilt quadrature colour clock level |
| phase_o | output | 2 | Current quarter-phase index |
| ph_stb_o | output | 4 | One-cycle entry strobe per phase |
| phase_valid_o | output | 1 | Phase index has two real samples behind it |
| mouse_a_o | output | MOUSE_W | Channel captured during colour clock high |
| mouse_b_o | output | MOUSE_W | Channel captured during colour clock low |

## Verification
The hardest case to reach is a phase change in the first cycle after reset. In that cycle the index would move, but the guard must block the strobe. The bench holds the colour clock high and the reference high through reset. The synchronizer flushes zeros, so the index passes through 3 before it settles on 0. This lets the bench check that the first change is suppressed and the second one fires. The hold behaviour of R8 is reached by stopping the colour clock mid-stream and then changing the mouse lines.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    localparam int NUM_PHASES = 4;
    localparam int PHASE_W    = $clog2(NUM_PHASES);

    typedef enum logic [PHASE_W-1:0] {
        PH_HI_EARLY = 2'd0,
        PH_HI_LATE  = 2'd1,
        PH_LO_EARLY = 2'd2,
        PH_LO_LATE  = 2'd3
    } ccs_phase_e;

    typedef struct packed {
        logic       cckq;
        ccs_phase_e idx;
    } ccs_phase_t;

    function automatic ccs_phase_e quad_of(input logic cck, input logic cckq);
        ccs_phase_e r;
        case ({cck, cckq})
            2'b10:   r = PH_HI_EARLY;
            2'b11:   r = PH_HI_LATE;
            2'b01:   r = PH_LO_EARLY;
            default: r = PH_LO_LATE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ccs_sync.sv
module ccs_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ccs_phase.sv
module ccs_phase
    import ccs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cck_s,
    input  logic                  ref_s,
    output logic                  cckq_o,
    output logic [PHASE_W-1:0]    phase_o,
    output logic [NUM_PHASES-1:0] stb_o,
    output logic                  valid_o
);
    localparam int SEEN_W    = 2;
    localparam int SEEN_NEED = 2;

    ccs_phase_t        cur_q;
    ccs_phase_e        prev_q;
    logic [SEEN_W-1:0] seen_q;
    logic              cckq_now;
    logic              moved;

    assign cckq_now = cck_s ^ ref_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '{cckq: 1'b0, idx: PH_HI_EARLY};
            prev_q <= PH_HI_EARLY;
            seen_q <= '0;
        end else begin
            cur_q.cckq <= cckq_now;
            cur_q.idx  <= quad_of(cck_s, cckq_now);
            prev_q     <= cur_q.idx;
            if (seen_q != SEEN_W'(SEEN_NEED)) seen_q <= seen_q + 1'b1;
        end
    end

    assign valid_o = (seen_q == SEEN_W'(SEEN_NEED));
    assign moved   = (cur_q.idx != prev_q);
    assign cckq_o  = cur_q.cckq;
    assign phase_o = cur_q.idx;

    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_stb
        assign stb_o[k] = valid_o && moved && (cur_q.idx == ccs_phase_e'(k));
    end
endmodule

// File: rtl/ccs_mouse_demux.sv
module ccs_mouse_demux #(
    parameter int MOUSE_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [MOUSE_W-1:0] mouse_s,
    input  logic               take_a,
    input  logic               take_b,
    output logic [MOUSE_W-1:0] chan_a_o,
    output logic [MOUSE_W-1:0] chan_b_o
);
    localparam int NUM_CH = 2;

    logic [MOUSE_W-1:0] aligned_q;
    logic [MOUSE_W-1:0] chan_q [NUM_CH];
    logic [NUM_CH-1:0]  take;

    assign take = {take_b, take_a};

    always_ff @(posedge clk) begin
        if (rst) aligned_q <= '0;
        else     aligned_q <= mouse_s;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)          chan_q[c] <= '0;
            else if (take[c]) chan_q[c] <= aligned_q;
        end
    end

    assign chan_a_o = chan_q[0];
    assign chan_b_o = chan_q[1];
endmodule

// File: rtl/ccs_strobe_gen.sv
module ccs_strobe_gen
    import ccs_pkg::*;
#(
    parameter int MOUSE_W     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ref_i,
    input  logic                  cck_i,
    input  logic [MOUSE_W-1:0]    mouse_i,
    output logic                  cckq_o,
    output logic [PHASE_W-1:0]    phase_o,
    output logic [NUM_PHASES-1:0] ph_stb_o,
    output logic                  phase_valid_o,
    output logic [MOUSE_W-1:0]    mouse_a_o,
    output logic [MOUSE_W-1:0]    mouse_b_o
);
    localparam int SYNC_W = MOUSE_W + 2;

    logic [SYNC_W-1:0] sync_d;
    logic [SYNC_W-1:0] sync_q;

    assign sync_d = {mouse_i, cck_i, ref_i};

    ccs_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sync_d),
        .q_o (sync_q)
    );

    ccs_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .cck_s   (sync_q[1]),
        .ref_s   (sync_q[0]),
        .cckq_o  (cckq_o),
        .phase_o (phase_o),
        .stb_o   (ph_stb_o),
        .valid_o (phase_valid_o)
    );

    ccs_mouse_demux #(.MOUSE_W(MOUSE_W)) u_demux (
        .clk      (clk),
        .rst      (rst),
        .mouse_s  (sync_q[SYNC_W-1:2]),
        .take_a   (ph_stb_o[PH_HI_LATE]),
        .take_b   (ph_stb_o[PH_LO_LATE]),
        .chan_a_o (mouse_a_o),
        .chan_b_o (mouse_b_o)
    );
endmodule

// File: rtl/ccs_strobe_gen_chk.sv
module ccs_strobe_gen_chk #(
    parameter int MOUSE_W = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               cckq_o,
    input logic [1:0]         phase_o,
    input logic [3:0]         ph_stb_o,
    input logic               phase_valid_o,
    input logic [MOUSE_W-1:0] mouse_a_o,
    input logic [MOUSE_W-1:0] mouse_b_o
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (ph_stb_o == 4'b0 && !phase_valid_o && mouse_a_o == '0 && mouse_b_o == '0 && !cckq_o));

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ph_stb_o));

    a_r4_strobe_phase: assert property (@(posedge clk) disable iff (rst)
        (ph_stb_o != 4'b0) |-> ph_stb_o[phase_o]);

    a_r5_guard: assert property (@(posedge clk) disable iff (rst)
        !phase_valid_o |-> (ph_stb_o == 4'b0));

    a_r6_hold_a: assert property (@(posedge clk) disable iff (rst)
        !ph_stb_o[1] |=> $stable(mouse_a_o));

    a_r7_hold_b: assert property (@(posedge clk) disable iff (rst)
        !ph_stb_o[3] |=> $stable(mouse_b_o));
endmodule

bind ccs_strobe_gen ccs_strobe_gen_chk #(.MOUSE_W(MOUSE_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cckq_o        (cckq_o),
    .phase_o       (phase_o),
    .ph_stb_o      (ph_stb_o),
    .phase_valid_o (phase_valid_o),
    .mouse_a_o     (mouse_a_o),
    .mouse_b_o     (mouse_b_o)
);

// File: tb/ccs_strobe_gen_bench.sv
module ccs_strobe_gen_bench;
    localparam int MW    = 2;
    localparam int QLEN  = 6;
    localparam int NVEC  = 8;
    localparam logic [3:0] VEC [NVEC] = '{4'b01_10, 4'b11_00, 4'b00_11, 4'b10_10,
                                          4'b01_01, 4'b00_00, 4'b11_11, 4'b10_01};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_i = 1'b0;
    logic          cck_i = 1'b0;
    logic [MW-1:0] mouse_i = '0;
    logic          cckq_o;
    logic [1:0]    phase_o;
    logic [3:0]    ph_stb_o;
    logic          phase_valid_o;
    logic [MW-1:0] mouse_a_o;
    logic [MW-1:0] mouse_b_o;

    int n_cmp = 0;
    int n_bad = 0;
    int stb_tot [4] = '{0, 0, 0, 0};
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ccs_strobe_gen #(.MOUSE_W(MW), .SYNC_STAGES(2)) u_ccs_strobe_gen (
        .clk(clk), .rst(rst), .ref_i(ref_i), .cck_i(cck_i), .mouse_i(mouse_i),
        .cckq_o(cckq_o), .phase_o(phase_o), .ph_stb_o(ph_stb_o),
        .phase_valid_o(phase_valid_o), .mouse_a_o(mouse_a_o), .mouse_b_o(mouse_b_o)
    );

    always @(negedge clk) begin
        for (int k = 0; k < 4; k++) if (ph_stb_o[k]) stb_tot[k] = stb_tot[k] + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive_q(input logic c, input logic r, input logic [MW-1:0] m);
        cck_i = c; ref_i = r; mouse_i = m;
        cyc(QLEN);
    endtask

    task automatic period(input logic [MW-1:0] a, input logic [MW-1:0] b);
        drive_q(1'b1, 1'b1, a);
        drive_q(1'b1, 1'b0, a);
        drive_q(1'b0, 1'b1, b);
        drive_q(1'b0, 1'b0, b);
    endtask

    initial begin
        int snap [4];
        logic [MW-1:0] last_a, last_b;
        // reset with colour clock high, reference high
        cck_i = 1'b1; ref_i = 1'b1; mouse_i = 2'b11;
        cyc(4);
        check(ph_stb_o == 4'b0 && !phase_valid_o, "R1 strobes/valid", ph_stb_o, 0);
        check(mouse_a_o == 0 && mouse_b_o == 0, "R1 channels", mouse_a_o, 0);
        check(!cckq_o && phase_o == 0, "R1 cckq/phase", {cckq_o, phase_o}, 0);
        rst = 1'b0;
        cyc(1);
        check(!phase_valid_o, "R5 valid after 1 edge", phase_valid_o, 0);
        check(ph_stb_o == 4'b0, "R5 early change suppressed", ph_stb_o, 0);
        cyc(1);
        check(phase_valid_o, "R5 valid after 2 edges", phase_valid_o, 1);
        check(ph_stb_o == 4'b0, "R5 no strobe yet", ph_stb_o, 0);
        cyc(1);
        check(ph_stb_o == 4'b0001, "R4 first entry strobe", ph_stb_o, 1);
        check(phase_o == 0 && !cckq_o, "R3 phase 0", phase_o, 0);

        // static encodings: cck, ref -> cckq, phase
        cck_i = 1'b1; ref_i = 1'b0; cyc(4);
        check(cckq_o == 1'b1, "R2 cckq 1^0", cckq_o, 1);
        check(phase_o == 1, "R3 phase (1,1)", phase_o, 1);
        cck_i = 1'b0; ref_i = 1'b1; cyc(4);
        check(cckq_o == 1'b1, "R2 cckq 0^1", cckq_o, 1);
        check(phase_o == 2, "R3 phase (0,1)", phase_o, 2);
        cck_i = 1'b0; ref_i = 1'b0; cyc(4);
        check(cckq_o == 1'b0, "R2 cckq 0^0", cckq_o, 0);
        check(phase_o == 3, "R3 phase (0,0)", phase_o, 3);

        // latency of R2: change at negedge, visible after 3 edges
        cck_i = 1'b1; ref_i = 1'b0;
        cyc(2);
        check(cckq_o == 1'b0, "R2 not yet after 2 edges", cckq_o, 0);
        cyc(1);
        check(cckq_o == 1'b1, "R2 visible after 3 edges", cckq_o, 1);
        cck_i = 1'b0; ref_i = 1'b0; cyc(6);

        // warm-up period, then the vector table
        period(2'b00, 2'b00);
        for (int v = 0; v < NVEC; v++) begin
            for (int k = 0; k < 4; k++) snap[k] = stb_tot[k];
            period(VEC[v][3:2], VEC[v][1:0]);
            check(mouse_a_o == VEC[v][3:2], "R6 channel A", mouse_a_o, VEC[v][3:2]);
            check(mouse_b_o == VEC[v][1:0], "R7 channel B", mouse_b_o, VEC[v][1:0]);
            for (int k = 0; k < 4; k++)
                check(stb_tot[k] - snap[k] == 1, "R4 one strobe per period",
                      stb_tot[k] - snap[k], 1);
        end

        // stalled colour clock: mouse changes must not reach the channels
        last_a = mouse_a_o; last_b = mouse_b_o;
        for (int k = 0; k < 4; k++) snap[k] = stb_tot[k];
        cck_i = 1'b0; ref_i = 1'b0;
        mouse_i = ~last_a; cyc(10);
        mouse_i = ~last_b; cyc(10);
        check(mouse_a_o == last_a, "R8 channel A held", mouse_a_o, last_a);
        check(mouse_b_o == last_b, "R8 channel B held", mouse_b_o, last_b);
        for (int k = 0; k < 4; k++)
            check(stb_tot[k] == snap[k], "R8 no strobe when stalled", stb_tot[k], snap[k]);

        // reset in mid-stream clears the channels again
        rst = 1'b1; cyc(2);
        check(mouse_a_o == 0 && mouse_b_o == 0 && !phase_valid_o, "R1 mid-run reset",
              {mouse_a_o, mouse_b_o}, 0);
        rst = 1'b0; cyc(2);
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule